// File: doc/BRIEF.md
# Processor Single-Step Ready Controller

This block drives the ready input of an 8-bit microprocessor so that an operator can let the processor run freely, advance it one bus cycle per button press, or advance it one whole instruction per button press. It is clocked by the processor's phase-2 clock, and its state updates on the rising edge of that clock. The processor samples ready on the falling edge, so the output is stable across that edge. The step button is a changeover type. Its pressed contact and its released contact arrive as separate inputs, and both are used for debouncing.

Two state bits form an escapement. The arm bit records that the current step has been used up. The release bit lets ready through for one phase-2 window. A press with the arm bit clear sets the release bit. In cycle mode the arm bit sets on the very next edge, so exactly one bus cycle runs. In instruction mode the arm bit sets when the opcode-fetch indicator rises, so the processor stops on the next opcode fetch. Only the released contact clears the arm bit. A parameter can derive the opcode-fetch indicator from a valid-data-address and valid-program-address pair instead. An external wait-state ready input is ANDed into the output.

Top module: `rdy_stepper`

## Requirements
- R1: Reset (rst=1, synchronous) clears both state bits. rdy is 0 while reset is held and stays 0 after it in halt mode (run_mode=0) until a press.
- R2: With run_mode=1, the stepper's ready bit is 1 from the next clock edge, and rdy equals wait_rdy.
- R3: In halt mode, a press (btn_pressed=1, btn_released=0) sampled at an edge while the arm bit is clear drives rdy to 1 for the cycle after that edge.
- R4: In cycle mode (cycle_mode=1), each press gives rdy=1 for exactly one clock cycle.
- R5: In instruction mode (cycle_mode=0), rdy stays 1 until an edge samples the opcode-fetch indicator at 1 after it was sampled at 0, and is 0 from that edge. An indicator held at 1 across cycles gives no new rise. After reset the indicator counts as previously 1.
- R6: After a step completes, no further step occurs until the released contact has been seen. With neither contact active, both state bits hold their values.
- R7: The released contact (btn_released=1) drives rdy to 0 after the next edge and clears the arm bit.
- R8: wait_rdy=0 forces rdy to 0 in the same cycle, whatever the stepper state.
- R9: With parameter USE_VALID_PAIR=1, the opcode-fetch indicator is vda AND vpa, and sync_in is ignored.
- R10: Both contacts active at once is treated as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor phase-2 clock; state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | 1 = run freely, 0 = halt/step |
| cycle_mode | input | 1 | 1 = one bus cycle per press, 0 = one instruction per press |
| btn_pressed | input | 1 | Pressed contact of the changeover button, active high |
| btn_released | input | 1 | Released contact of the changeover button, active high |
| sync_in | input | 1 | Opcode-fetch indicator from the processor |
| vda | input | 1 | Valid-data-address signal (used when USE_VALID_PAIR=1) |
| vpa | input | 1 | Valid-program-address signal (used when USE_VALID_PAIR=1) |
| wait_rdy | input | 1 | External wait-state ready, ANDed into the output |
| rdy | output | 1 | Ready to the processor |

## Verification
A stuck-set release bit shows at rdy as one extra ready cycle, in the cycle right after a step should have ended. A cycle-mode step then stretches to two cycles, or rdy fails to drop at the edge where the opcode-fetch indicator rises. An arm bit that clears without the released contact shows as a second step while the button is still held, within one cycle. A lost indicator history shows as a halt that comes too early, or no halt, on the first edge where the indicator is high. Every such fault appears at rdy within one or two clock cycles of the stimulus.

// File: rtl/rdy_step_pkg.sv
package rdy_step_pkg;
  // Decoded position of the changeover step button
  typedef enum logic [1:0] {
    BTN_MID  = 2'd0,  // between contacts: hold state
    BTN_DOWN = 2'd1,  // pressed contact only
    BTN_UP   = 2'd2   // released contact (wins if both are active)
  } btn_pos_e;

  function automatic btn_pos_e decode_btn(input logic pressed, input logic released);
    if (released)     return BTN_UP;
    else if (pressed) return BTN_DOWN;
    else              return BTN_MID;
  endfunction
endpackage

// File: rtl/rdy_sync_src.sv
module rdy_sync_src #(
  parameter bit USE_VALID_PAIR = 1'b0,
  parameter bit HIST_RESET     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic vda,
  input  logic vpa,
  output logic sync_rise
);
  logic sync_eff;
  logic sync_q;

  // Source selection: a valid-address pair stands in for a missing fetch pin
  assign sync_eff = USE_VALID_PAIR ? (vda & vpa) : sync_in;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= HIST_RESET;
    else     sync_q <= sync_eff;
  end

  assign sync_rise = sync_eff & ~sync_q;
endmodule

// File: rtl/rdy_arm_flop.sv
module rdy_arm_flop
  import rdy_step_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  btn_pos_e btn,
  input  logic     cycle_mode,
  input  logic     sync_rise,
  input  logic     rel_q,
  output logic     arm_next,
  output logic     arm_q
);
  logic trip;

  // Cycle mode trips one edge after release; instruction mode on fetch rise
  assign trip = cycle_mode ? rel_q : sync_rise;

  always_comb begin
    if (btn == BTN_UP) arm_next = 1'b0;
    else if (trip)     arm_next = 1'b1;
    else               arm_next = arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= arm_next;
  end
endmodule

// File: rtl/rdy_release_flop.sv
module rdy_release_flop
  import rdy_step_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run_mode,
  input  btn_pos_e btn,
  input  logic     arm_next,
  output logic     rel_q
);
  logic rel_next;

  always_comb begin
    if (run_mode)             rel_next = 1'b1;
    else if (btn == BTN_UP)   rel_next = 1'b0;
    else if (arm_next)        rel_next = 1'b0;
    else if (btn == BTN_DOWN) rel_next = 1'b1;
    else                      rel_next = rel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rel_q <= 1'b0;
    else     rel_q <= rel_next;
  end
endmodule

// File: rtl/rdy_stepper.sv
module rdy_stepper
  import rdy_step_pkg::*;
#(
  parameter bit USE_VALID_PAIR = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic run_mode,
  input  logic cycle_mode,
  input  logic btn_pressed,
  input  logic btn_released,
  input  logic sync_in,
  input  logic vda,
  input  logic vpa,
  input  logic wait_rdy,
  output logic rdy
);
  btn_pos_e btn;
  logic     sync_rise;
  logic     arm_next;
  logic     arm_q;
  logic     rel_q;

  assign btn = decode_btn(btn_pressed, btn_released);

  rdy_sync_src #(.USE_VALID_PAIR(USE_VALID_PAIR), .HIST_RESET(1'b1)) u_sync (
    .clk(clk), .rst(rst), .sync_in(sync_in), .vda(vda), .vpa(vpa),
    .sync_rise(sync_rise)
  );

  rdy_arm_flop u_arm (
    .clk(clk), .rst(rst), .btn(btn), .cycle_mode(cycle_mode),
    .sync_rise(sync_rise), .rel_q(rel_q), .arm_next(arm_next), .arm_q(arm_q)
  );

  rdy_release_flop u_rel (
    .clk(clk), .rst(rst), .run_mode(run_mode), .btn(btn),
    .arm_next(arm_next), .rel_q(rel_q)
  );

  // Stepper bit is a flop; wait-state ready joins without a register stage
  assign rdy = rel_q & wait_rdy;
endmodule

// File: rtl/rdy_stepper_chk.sv
module rdy_stepper_chk (
  input logic clk,
  input logic rst,
  input logic run_mode,
  input logic cycle_mode,
  input logic btn_pressed,
  input logic btn_released,
  input logic arm_q,
  input logic rel_q
);
  // R2: run mode sets the stepper ready bit at the next edge
  a_r2_run_sets_ready: assert property (@(posedge clk) disable iff (rst)
    run_mode |=> rel_q);

  // R3: a clean press with nothing armed in cycle mode opens one window
  a_r3_press_opens: assert property (@(posedge clk) disable iff (rst)
    (!run_mode && cycle_mode && btn_pressed && !btn_released && !arm_q && !rel_q) |=> rel_q);

  // R4: in cycle mode an open window closes after one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (!run_mode && cycle_mode && rel_q) |=> !rel_q);

  // R6: the arm bit survives every edge without the released contact
  a_r6_arm_holds: assert property (@(posedge clk) disable iff (rst)
    (arm_q && !btn_released) |=> arm_q);

  // R7: the released contact closes the window and clears the arm bit
  a_r7_release_clears: assert property (@(posedge clk) disable iff (rst)
    (btn_released && !run_mode) |=> (!rel_q && !arm_q));
endmodule

bind rdy_stepper rdy_stepper_chk u_chk (
  .clk(clk), .rst(rst), .run_mode(run_mode), .cycle_mode(cycle_mode),
  .btn_pressed(btn_pressed), .btn_released(btn_released),
  .arm_q(arm_q), .rel_q(rel_q)
);

// File: tb/tb_rdy_stepper.sv
`timescale 1ns/1ps
module tb_rdy_stepper;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_mode = 1'b0, cycle_mode = 1'b0;
  logic btn_pressed = 1'b0, btn_released = 1'b1;
  logic sync_in = 1'b0, vda = 1'b0, vpa = 1'b0, wait_rdy = 1'b1;
  logic rdy, rdy2;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rdy_stepper dut (
    .clk(clk), .rst(rst), .run_mode(run_mode), .cycle_mode(cycle_mode),
    .btn_pressed(btn_pressed), .btn_released(btn_released), .sync_in(sync_in),
    .vda(vda), .vpa(vpa), .wait_rdy(wait_rdy), .rdy(rdy)
  );

  rdy_stepper #(.USE_VALID_PAIR(1'b1)) dut2 (
    .clk(clk), .rst(rst), .run_mode(run_mode), .cycle_mode(cycle_mode),
    .btn_pressed(btn_pressed), .btn_released(btn_released), .sync_in(sync_in),
    .vda(vda), .vpa(vpa), .wait_rdy(wait_rdy), .rdy(rdy2)
  );

  // {run, cycle, pressed, released, sync, wait, expected rdy}
  localparam int NV = 28;
  localparam logic [6:0] VEC [0:NV-1] = '{
    7'b0101010, 7'b0110011, 7'b0110010, 7'b0110010, 7'b0100010, 7'b0101010,
    7'b0110011, 7'b0110000, 7'b0101010,
    7'b0001010, 7'b0010011, 7'b0010011, 7'b0010000, 7'b0010110, 7'b0010110,
    7'b0001110, 7'b0010111, 7'b0010111, 7'b0000011, 7'b0010110, 7'b0001010,
    7'b0011010, 7'b0010011, 7'b0001010,
    7'b1001011, 7'b1010000, 7'b1000111, 7'b0001010
  };

  function automatic string tag_of(input int i);
    case (i)
      1, 10, 22:          return "R3";
      2, 6:               return "R4";
      3, 4, 14, 18:       return "R6";
      7, 12, 25:          return "R8";
      11, 13, 16, 17, 19: return "R5";
      21:                 return "R10";
      24, 26:             return "R2";
      default:            return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdy=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic r, input logic c, input logic p, input logic l,
                       input logic s, input logic w);
    run_mode = r; cycle_mode = c; btn_pressed = p; btn_released = l;
    sync_in = s; wait_rdy = w;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    // R1: reset holds ready low even in run mode
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    rst = 1'b1;
    tick(); tick();
    check("R1", rdy, 1'b0);
    check("R1", rdy2, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    tick();
    check("R1", rdy, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      tick();
      check(tag_of(i), rdy, VEC[i][0]);
    end

    // R9: valid-address pair variant, instruction mode
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); vda = 1'b0; vpa = 1'b0;
    tick();
    check("R9", rdy2, 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1); vda = 1'b1; vpa = 1'b0;
    tick();
    check("R9", rdy2, 1'b1);  // sync_in rise ignored
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1); vda = 1'b1; vpa = 1'b1;
    tick();
    check("R9", rdy2, 1'b0);  // pair rise halts

    // R1: reset in the middle of a step
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); vda = 1'b0; vpa = 1'b0;
    tick();
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    tick();
    check("R3", rdy, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    tick();
    check("R1", rdy, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    tick();
    check("R1", rdy, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule